// File: doc/BRIEF.md
# Vectored Interrupt Priority Unit

This block keeps the interrupt state of one processor as three bit vectors, one bit per vector number: pending requests, vectors in service, and the trigger mode recorded for each request. A device side posts a vector with its trigger mode. The processor side reads and writes a small register window and pulses an acknowledge strobe when it takes an interrupt. The block raises its interrupt line when the most urgent pending request outranks the current processor priority.

Priority follows the vector number, so the highest set bit wins. Vectors are grouped into classes of sixteen by their upper nibble. The processor priority is formed from the software task priority and the class of the highest vector in service. An acknowledge moves the top request into service and returns its number; when the request does not beat the task priority, the block returns the spurious vector instead and changes nothing. An end-of-interrupt write retires the highest vector in service.

Top module: `irq_prio_core`

## Requirements
- R1: After reset the interrupt line, the acknowledged vector and the address-error flag are 0. Task priority reads 0, the spurious register reads 0x0FF (bit 8, the enable, clear), and all request, in-service and trigger-mode words read 0.
- R2: A posted vector sets its request bit. The same cycle sets its trigger-mode bit when post_level is 1 (level) and clears it when post_level is 0 (edge). Vector v sits in word v/32, bit v%32, of each bank.
- R3: Among pending requests, the highest vector number is the one an acknowledge takes.
- R4: The processor priority (offset 0x0A0, read-only) equals the task priority when the task priority's upper nibble is at least the class of the highest in-service vector. Otherwise it equals that class shifted left by four. An empty in-service set counts as class 0.
- R5: The interrupt line is 1 only when all of these hold: spurious-register bit 8 is set; a request is pending; and either the processor priority is 0 or the top request's upper nibble exceeds the processor priority's upper nibble.
- R6: On acknowledge the block returns the low byte of the spurious register and changes no bank in any of three cases: bit 8 is clear, nothing is pending, or the task priority is nonzero and the top request is at or below it. Otherwise it returns the top request, clears its request bit and sets its in-service bit. ack_vector shows the result after the clock edge that samples ack.
- R7: A write to offset 0x0B0 clears only the highest set in-service bit. With no bit in service it changes nothing.
- R8: Writes keep 8 bits of the task priority (offset 0x080) and 9 bits of the spurious register (offset 0x0F0), and read back those values.
- R9: The banks read at 0x100+16k (in service), 0x180+16k (trigger mode) and 0x200+16k (request), with k from 0 to 7. Writes to these offsets, and to 0x0A0, are ignored without error. A read of an unmapped offset returns 0. A read or write of an unmapped offset sets addr_err, and addr_err stays set until reset. Offset 0x0B0 is write-only.
- R10: If a post and an acknowledge name the same vector in one cycle, the request bit stays set. If an end-of-interrupt and an acknowledge fall in one cycle, both take effect: the old top in-service bit is cleared and the acknowledged bit is set.
- R11: The interrupt line follows the registered state, so it reflects a post, acknowledge, end-of-interrupt or task-priority write at the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | 1 | Post a request this cycle |
| post_vector | input | 8 | Vector number being posted |
| post_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack | input | 1 | Acknowledge strobe from the processor |
| ack_vector | output | 8 | Vector returned by the last acknowledge |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset into the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is 1 |
| irq | output | 1 | Interrupt line to the processor |
| addr_err | output | 1 | Sticky unmapped-access flag |

## Verification
Two pairs of events can land in the same cycle. The first is a post and an acknowledge of the same vector. The second is an end-of-interrupt write and an acknowledge. The bench drives each pair on one clock edge, with the vector already pending and already in service. It then reads the request and in-service words through the register window: the request bit must survive the post, and the in-service bit must be cleared by the end-of-interrupt and set again by the acknowledge.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

   localparam int WORD_W = 32;

   // register word indices (byte offset >> 4)
   localparam int WI_TPR = 8'h08;
   localparam int WI_PPR = 8'h0A;
   localparam int WI_EOI = 8'h0B;
   localparam int WI_SVR = 8'h0F;
   localparam int WI_ISR = 8'h10;
   localparam int WI_TMR = 8'h18;
   localparam int WI_IRR = 8'h20;

   localparam logic [8:0] SVR_RESET = 9'h0FF;

   typedef enum logic [2:0] {
      RG_NONE, RG_TPR, RG_PPR, RG_EOI, RG_SVR, RG_ISR, RG_TMR, RG_IRR
   } region_e;

endpackage

// File: rtl/irqp_find_top.sv
module irqp_find_top #(
   parameter int N        = 256,
   parameter bit TREE_ENC = 1'b1,
   localparam int IW      = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   localparam int NW = N / 32;

   if (N < 32 || (N % 32) != 0) begin : g_bad_n
      $error("irqp_find_top: N must be a multiple of 32");
   end

   assign any = |vec;

   if (TREE_ENC) begin : g_tree
      logic [NW-1:0] wany;
      for (genvar w = 0; w < NW; w++) begin : g_w
         assign wany[w] = |vec[w*32 +: 32];
      end
      always_comb begin
         int          wsel;
         int          bsel;
         logic [31:0] wrd;
         wsel = 0;
         bsel = 0;
         for (int w = 0; w < NW; w++) if (wany[w]) wsel = w;
         wrd = vec[wsel*32 +: 32];
         for (int b = 0; b < 32; b++) if (wrd[b]) bsel = b;
         idx = IW'(wsel * 32 + bsel);
      end
   end else begin : g_linear
      always_comb begin
         idx = '0;
         for (int i = 0; i < N; i++) if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/irqp_vec_bank.sv
module irqp_vec_bank #(
   parameter int N = 256
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_m,
   input  logic [N-1:0] clr_m,
   output logic [N-1:0] q
);
   // set wins over clear so a new event is never lost
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_m) | set_m;
   end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core #(
   parameter int NVEC     = 256,
   parameter int AW       = 12,
   parameter bit TREE_ENC = 1'b1,
   localparam int VW      = $clog2(NVEC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          post_valid,
   input  logic [VW-1:0] post_vector,
   input  logic          post_level,
   input  logic          ack,
   output logic [VW-1:0] ack_vector,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [AW-1:0] reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          irq,
   output logic          addr_err
);
   import irqp_pkg::*;

   localparam int NWORD = NVEC / WORD_W;
   localparam int XW    = AW - 4;
   localparam logic [NVEC-1:0] ONE = NVEC'(1);

   if (NVEC != 32 && NVEC != 64 && NVEC != 128 && NVEC != 256) begin : g_bad_nvec
      $error("irq_prio_core: NVEC must be 32, 64, 128 or 256");
   end
   if (AW < 10) begin : g_bad_aw
      $error("irq_prio_core: AW too small for the register window");
   end

   // ---------------- state ----------------
   logic [7:0]      tpr_q;
   logic [8:0]      svr_q;
   logic [VW-1:0]   ack_vec_q;
   logic            err_q;
   logic [NVEC-1:0] irr_q, isr_q, tmr_q;
   logic [NVEC-1:0] irr_set, irr_clr, isr_set, isr_clr, tmr_set, tmr_clr;

   irqp_vec_bank #(.N(NVEC)) i_irr (.clk(clk), .rst_n(rst_n), .set_m(irr_set), .clr_m(irr_clr), .q(irr_q));
   irqp_vec_bank #(.N(NVEC)) i_isr (.clk(clk), .rst_n(rst_n), .set_m(isr_set), .clr_m(isr_clr), .q(isr_q));
   irqp_vec_bank #(.N(NVEC)) i_tmr (.clk(clk), .rst_n(rst_n), .set_m(tmr_set), .clr_m(tmr_clr), .q(tmr_q));

   // ---------------- priority ----------------
   logic          irr_any, isr_any;
   logic [VW-1:0] irr_idx, isr_idx;

   irqp_find_top #(.N(NVEC), .TREE_ENC(TREE_ENC)) i_irr_top (.vec(irr_q), .any(irr_any), .idx(irr_idx));
   irqp_find_top #(.N(NVEC), .TREE_ENC(TREE_ENC)) i_isr_top (.vec(isr_q), .any(isr_any), .idx(isr_idx));

   logic [7:0] irr8, isr8, ppr;
   logic [3:0] isr_cls;
   logic       take;

   assign irr8    = 8'(irr_idx);
   assign isr8    = 8'(isr_idx);
   assign isr_cls = isr_any ? isr8[7:4] : 4'h0;
   assign ppr     = (tpr_q[7:4] >= isr_cls) ? tpr_q : {isr_cls, 4'h0};
   assign irq     = svr_q[8] && irr_any && (ppr == 8'h00 || irr8[7:4] > ppr[7:4]);
   assign take    = ack && svr_q[8] && irr_any && !(tpr_q != 8'h00 && irr8 <= tpr_q);

   // ---------------- register decode ----------------
   region_e     region;
   int          woff;
   logic [XW-1:0] wsel;
   logic        rd_ok, wr_ok, eoi;

   assign wsel = reg_addr[AW-1:4];

   always_comb begin
      region = RG_NONE;
      woff   = 0;
      if      (wsel == XW'(WI_TPR)) region = RG_TPR;
      else if (wsel == XW'(WI_PPR)) region = RG_PPR;
      else if (wsel == XW'(WI_EOI)) region = RG_EOI;
      else if (wsel == XW'(WI_SVR)) region = RG_SVR;
      else if (wsel >= XW'(WI_ISR) && wsel < XW'(WI_ISR + NWORD)) begin
         region = RG_ISR; woff = int'(wsel) - WI_ISR;
      end else if (wsel >= XW'(WI_TMR) && wsel < XW'(WI_TMR + NWORD)) begin
         region = RG_TMR; woff = int'(wsel) - WI_TMR;
      end else if (wsel >= XW'(WI_IRR) && wsel < XW'(WI_IRR + NWORD)) begin
         region = RG_IRR; woff = int'(wsel) - WI_IRR;
      end
   end

   assign wr_ok = (region != RG_NONE);
   assign rd_ok = (region != RG_NONE) && (region != RG_EOI);
   assign eoi   = reg_wr && (region == RG_EOI);

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         unique case (region)
            RG_TPR:  reg_rdata = {24'h0, tpr_q};
            RG_PPR:  reg_rdata = {24'h0, ppr};
            RG_SVR:  reg_rdata = {23'h0, svr_q};
            RG_ISR:  reg_rdata = isr_q[woff*32 +: 32];
            RG_TMR:  reg_rdata = tmr_q[woff*32 +: 32];
            RG_IRR:  reg_rdata = irr_q[woff*32 +: 32];
            default: reg_rdata = '0;
         endcase
      end
   end

   // ---------------- bank updates ----------------
   assign irr_set = post_valid               ? (ONE << post_vector) : '0;
   assign tmr_set = (post_valid && post_level)  ? (ONE << post_vector) : '0;
   assign tmr_clr = (post_valid && !post_level) ? (ONE << post_vector) : '0;
   assign irr_clr = take                     ? (ONE << irr_idx)     : '0;
   assign isr_set = take                     ? (ONE << irr_idx)     : '0;
   assign isr_clr = (eoi && isr_any)         ? (ONE << isr_idx)     : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tpr_q     <= 8'h00;
         svr_q     <= SVR_RESET;
         ack_vec_q <= '0;
         err_q     <= 1'b0;
      end else begin
         if (reg_wr && region == RG_TPR) tpr_q <= reg_wdata[7:0];
         if (reg_wr && region == RG_SVR) svr_q <= reg_wdata[8:0];
         if (ack) ack_vec_q <= take ? irr_idx : VW'(svr_q[7:0]);
         if ((reg_rd && !rd_ok) || (reg_wr && !wr_ok)) err_q <= 1'b1;
      end
   end

   assign ack_vector = ack_vec_q;
   assign addr_err   = err_q;

   // ---------------- assertions ----------------
   // R2
   post_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |=> irr_q[$past(post_vector)]);
   // R2
   post_trig_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      post_valid |=> tmr_q[$past(post_vector)] == $past(post_level));
   // R6
   take_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> isr_q[ack_vec_q] && ack_vec_q == $past(irr_idx));
   // R6
   spurious_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !take && !post_valid && !eoi) |=> $stable(irr_q) && $stable(isr_q));
   // R7
   eoi_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !take && isr_any) |=> $countones(isr_q) == $past($countones(isr_q)) - 1);
   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |=> addr_err);

endmodule

// File: tb/test_irq_prio_core.sv
module test_irq_prio_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        post_valid, post_level, ack, reg_wr, reg_rd, irq, addr_err;
   logic [7:0]  post_vector, ack_vector;
   logic [11:0] reg_addr;
   logic [31:0] reg_wdata, reg_rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   irq_prio_core i_irq_prio_core (
      .clk(clk), .rst_n(rst_n),
      .post_valid(post_valid), .post_vector(post_vector), .post_level(post_level),
      .ack(ack), .ack_vector(ack_vector),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .addr_err(addr_err)
   );

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
      end
   endtask

   task automatic post(input logic [7:0] v, input logic lvl);
      @(negedge clk);
      post_valid = 1'b1; post_vector = v; post_level = lvl;
      @(negedge clk);
      post_valid = 1'b0;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input string r, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #2 check(r, reg_rdata, exp);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // driver side of the scoreboard: expected vector goes into the queue
   task automatic do_ack(input string r, input logic [7:0] exp);
      exp_q.push_back(exp); tag_q.push_back(r);
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   // monitor side: compare each acknowledge result as it appears
   initial begin
      forever begin
         @(posedge clk);
         if (ack === 1'b1) begin
            @(negedge clk);
            #1;
            if (exp_q.size() == 0) begin
               check("R6 unexpected ack", 32'(ack_vector), 32'hFFFF_FFFF);
            end else begin
               check(tag_q.pop_front(), 32'(ack_vector), 32'(exp_q.pop_front()));
            end
         end
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; post_valid = 1'b0; post_vector = '0; post_level = 1'b0;
      ack = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq", 32'(irq), 0);
      check("R1 ack_vector", 32'(ack_vector), 0);
      check("R1 addr_err", 32'(addr_err), 0);
      rd("R1 tpr", 12'h080, 0);
      rd("R1 svr", 12'h0F0, 32'h0FF);
      rd("R1 ppr", 12'h0A0, 0);
      rd("R1 irr7", 12'h270, 0);
      rd("R1 isr0", 12'h100, 0);

      // R2 edge post while disabled
      post(8'h45, 1'b0);
      rd("R2 irr2", 12'h220, 32'h20);
      rd("R2 tmr2 edge", 12'h1A0, 0);
      check("R5 irq disabled", 32'(irq), 0);
      do_ack("R6 disabled spurious", 8'hFF);
      rd("R6 irr kept", 12'h220, 32'h20);

      // R8 spurious register keeps 9 bits, enable
      wr(12'h0F0, 32'hFFFF_F1FF);
      rd("R8 svr", 12'h0F0, 32'h1FF);
      check("R5 irq enabled", 32'(irq), 1);

      // R2 level post, R3 highest taken
      post(8'h93, 1'b1);
      rd("R2 tmr4 level", 12'h1C0, 32'h0008_0000);
      do_ack("R3 top vector", 8'h93);
      rd("R6 isr4 set", 12'h140, 32'h0008_0000);
      rd("R6 irr4 clear", 12'h240, 0);
      rd("R4 ppr from isr", 12'h0A0, 32'h90);
      check("R5 irq class below ppr", 32'(irq), 0);

      // R8 task priority keeps 8 bits, R4 tpr dominates
      wr(12'h080, 32'h1A5);
      rd("R8 tpr", 12'h080, 32'hA5);
      rd("R4 ppr from tpr", 12'h0A0, 32'hA5);

      // R7 end of interrupt
      wr(12'h0B0, 0);
      rd("R7 isr4 cleared", 12'h140, 0);
      do_ack("R6 below tpr spurious", 8'hFF);
      rd("R6 irr2 kept", 12'h220, 32'h20);

      // tpr 0x40: same class, no line, but acknowledge accepted
      wr(12'h080, 32'h40);
      check("R5 irq equal class", 32'(irq), 0);
      do_ack("R6 above tpr taken", 8'h45);
      rd("R6 isr2", 12'h120, 32'h20);
      rd("R4 ppr equal class", 12'h0A0, 32'h40);
      wr(12'h080, 32'h00);
      rd("R4 ppr isr class", 12'h0A0, 32'h40);

      // nested service
      post(8'h30, 1'b0);
      post(8'h70, 1'b0);
      check("R5 irq higher class", 32'(irq), 1);
      do_ack("R3 highest of two", 8'h70);
      do_ack("R3 next", 8'h30);
      check("R5 irq none pending", 32'(irq), 0);
      wr(12'h0B0, 0);
      rd("R7 isr3 top cleared", 12'h130, 0);
      rd("R7 isr1 kept", 12'h110, 32'h0001_0000);
      rd("R7 isr2 kept", 12'h120, 32'h20);
      wr(12'h0B0, 0);
      wr(12'h0B0, 0);
      wr(12'h0B0, 0);
      rd("R7 isr1 empty", 12'h110, 0);
      rd("R7 isr2 empty", 12'h120, 0);
      rd("R7 ppr idle", 12'h0A0, 0);

      // R9 read-only and unmapped accesses
      wr(12'h100, 32'hFFFF_FFFF);
      rd("R9 isr write ignored", 12'h100, 0);
      wr(12'h0A0, 32'hFF);
      rd("R9 ppr write ignored", 12'h0A0, 0);
      check("R9 no err yet", 32'(addr_err), 0);
      rd("R9 unmapped reads zero", 12'h300, 0);
      check("R9 err set", 32'(addr_err), 1);

      // R6 nothing pending returns spurious low byte
      wr(12'h0F0, 32'h1A7);
      do_ack("R6 empty spurious", 8'hA7);

      // R10 post and ack of the same vector in one cycle
      post(8'h60, 1'b0);
      exp_q.push_back(8'h60); tag_q.push_back("R10 post+ack");
      @(negedge clk);
      post_valid = 1'b1; post_vector = 8'h60; ack = 1'b1;
      @(negedge clk);
      post_valid = 1'b0; ack = 1'b0;
      rd("R10 irr3 kept", 12'h230, 32'h1);
      rd("R10 isr3 set", 12'h130, 32'h1);

      // R10 end of interrupt and ack in one cycle
      exp_q.push_back(8'h60); tag_q.push_back("R10 eoi+ack");
      @(negedge clk);
      ack = 1'b1; reg_wr = 1'b1; reg_addr = 12'h0B0; reg_wdata = 0;
      @(negedge clk);
      ack = 1'b0; reg_wr = 1'b0;
      rd("R10 isr3 reset", 12'h130, 32'h1);
      rd("R10 irr3 taken", 12'h230, 0);

      // R11 line timing
      wr(12'h0B0, 0);
      @(negedge clk);
      post_valid = 1'b1; post_vector = 8'h80; post_level = 1'b0;
      #2 check("R11 irq before edge", 32'(irq), 0);
      @(negedge clk);
      post_valid = 1'b0;
      check("R11 irq after edge", 32'(irq), 1);
      wr(12'h080, 32'h90);
      check("R11 irq after tpr", 32'(irq), 0);

      repeat (3) @(negedge clk);
      check("R6 queue drained", 32'(exp_q.size()), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule